// File: doc/BRIEF.md
# SDRAM Row-Activation Timing Guard

This block sits between a command source and the command pins of a four-bank SDRAM. It keeps a record of which banks have an open row. It also keeps cycle counters for each bank and one counter shared by all banks. With these it decides, cycle by cycle, whether the requested ACTIVE, READ, WRITE or PRECHARGE may go out now or must wait. A request that cannot go out yet is held off: grant stays low and the bus carries a NOP. The requester keeps the same request on its inputs until grant rises.

The timing limits are given as parameters in nanoseconds, together with the clock period. At elaboration each limit becomes a whole number of cycles by ceiling division, with a minimum of one. Granted commands are registered onto the chip-select, row-strobe, column-strobe and write-enable lines, with bank and address, one cycle after the grant.

Top module: `sdram_act_guard`

## Requirements
- R1: Reset is synchronous and active low. After reset the bus carries NOP, every bank is closed and every timer has expired, so a first ACTIVE to any bank is granted in the same cycle it is requested.
- R2: The command code `req_cmd` is 0 for ACTIVE, 1 for READ, 2 for WRITE and 3 for PRECHARGE. A command granted in cycle t appears on the bus in cycle t+1, together with the requested bank and address. Bus levels `{cs_n,ras_n,cas_n,we_n}` are: ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010.
- R3: In any cycle that follows a cycle with no grant, the bus carries NOP: `{cs_n,ras_n,cas_n,we_n}` = 0111.
- R4: A READ or WRITE to a bank that has no open row is never granted.
- R5: A READ or WRITE to a bank is granted no earlier than RCD cycles after that bank's ACTIVE was granted. RCD is ceil(T_RCD_NS / CLK_PERIOD_NS); for example, 25 ns at a 10 ns period gives 3 cycles.
- R6: An ACTIVE to a bank that already has an open row is held off until a PRECHARGE to that bank has been granted.
- R7: Two ACTIVE commands to the same bank are granted at least RC = ceil(T_RC_NS / CLK_PERIOD_NS) cycles apart.
- R8: Two ACTIVE commands to different banks are granted at least RRD = ceil(T_RRD_NS / CLK_PERIOD_NS) cycles apart.
- R9: An ACTIVE to a bank is granted no earlier than RP = ceil(T_RP_NS / CLK_PERIOD_NS) cycles after a PRECHARGE to that bank. A limit that divides exactly, such as 20 ns at 10 ns, gives exactly 2 cycles.
- R10: A PRECHARGE is granted in the cycle it is requested, whether the bank is open or closed, and it leaves the bank closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present |
| req_cmd | input | 2 | Requested command: 0 ACTIVE, 1 READ, 2 WRITE, 3 PRECHARGE |
| req_bank | input | 2 | Target bank |
| req_addr | input | 12 | Row address for ACTIVE, column address for READ and WRITE |
| grant | output | 1 | The request goes out at the next edge |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address on the bus |
| addr | output | 12 | Address on the bus |

## Verification
The hardest situation to reach is one where two limits hold off the same ACTIVE and expire at different times. In that case the recovery after a precharge ends early, while the same-bank spacing from an earlier activation is still running. The stimulus gets there by opening a bank, closing it in the very next free cycle and asking again at once, so the measured stall must follow the longer limit. It also reaches an exact-division limit and a reset applied while a bank is open. Each stall is measured in whole cycles against counts that the bench computes from the nanosecond parameters.

// File: rtl/sdram_guard_pkg.sv
// Shared types and helpers for the SDRAM row-activation timing guard.
// Assumes all timing limits are positive integers in nanoseconds.
package sdram_guard_pkg;

    typedef enum logic [1:0] {
        CMD_ACT = 2'd0,
        CMD_RD  = 2'd1,
        CMD_WR  = 2'd2,
        CMD_PRE = 2'd3
    } req_cmd_e;

    // Ceiling division of a limit by the clock period, never below one cycle.
    function automatic int ns_to_cyc(input int limit_ns, input int period_ns);
        int c;
        c = (limit_ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    // Counter width large enough to hold a value up to max_val.
    function automatic int cnt_width(input int max_val);
        int w;
        w = 1;
        while ((1 << w) <= max_val) w++;
        return w;
    endfunction

endpackage

// File: rtl/sdram_delay_cnt.sv
// Down-counter that measures a minimum spacing after a start pulse.
// A start in cycle t makes expired true again from cycle t+CYC onward.
// Assumes CYC >= 1 and that W can hold CYC-1.
module sdram_delay_cnt #(
    parameter int CYC = 3,
    parameter int W   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    logic [W-1:0] cnt;

    // Load on start, otherwise count down to zero and rest there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= W'(CYC - 1);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sdram_bank_state.sv
// Per-bank record: open flag plus activation and precharge timers.
// Assumes act_go and pre_go are never asserted together.
module sdram_bank_state #(
    parameter int RCD_CYC = 3,
    parameter int RC_CYC  = 7,
    parameter int RP_CYC  = 2,
    parameter int W       = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_go,
    input  logic pre_go,
    output logic is_open,
    output logic rw_ready,
    output logic act_ready
);
    logic rcd_done;
    logic rc_done;
    logic rp_done;

    // Track whether the bank currently holds an open row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_open <= 1'b0;
        end else if (act_go) begin
            is_open <= 1'b1;
        end else if (pre_go) begin
            is_open <= 1'b0;
        end
    end

    sdram_delay_cnt #(.CYC(RCD_CYC), .W(W)) u_rcd (
        .clk(clk), .rst_n(rst_n), .start(act_go), .expired(rcd_done)
    );
    sdram_delay_cnt #(.CYC(RC_CYC), .W(W)) u_rc (
        .clk(clk), .rst_n(rst_n), .start(act_go), .expired(rc_done)
    );
    sdram_delay_cnt #(.CYC(RP_CYC), .W(W)) u_rp (
        .clk(clk), .rst_n(rst_n), .start(pre_go), .expired(rp_done)
    );

    // Combine the flag and timers into the per-command readiness.
    always_comb begin
        rw_ready  = is_open && rcd_done;
        act_ready = !is_open && rc_done && rp_done;
    end
endmodule

// File: rtl/sdram_cmd_encode.sv
// Registers a granted command onto the active-low SDRAM command lines.
// With no grant the lines carry NOP and bank and address fall to zero.
module sdram_cmd_encode
    import sdram_guard_pkg::*;
#(
    parameter int BA_W   = 2,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  req_cmd_e          cmd,
    input  logic [BA_W-1:0]   bank,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);
    logic [2:0] rcw_next;

    // Map the command to row-strobe, column-strobe and write-enable levels.
    always_comb begin
        rcw_next = 3'b111;
        if (fire) begin
            unique case (cmd)
                CMD_ACT: rcw_next = 3'b011;
                CMD_RD:  rcw_next = 3'b101;
                CMD_WR:  rcw_next = 3'b100;
                CMD_PRE: rcw_next = 3'b010;
            endcase
        end
    end

    // Register the bus so that it changes only at clock edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n  <= 1'b0;
            ras_n <= 1'b1;
            cas_n <= 1'b1;
            we_n  <= 1'b1;
            ba    <= '0;
            addr  <= '0;
        end else begin
            cs_n  <= 1'b0;
            {ras_n, cas_n, we_n} <= rcw_next;
            ba    <= fire ? bank : '0;
            addr  <= fire ? addr_in : '0;
        end
    end
endmodule

// File: rtl/sdram_act_guard.sv
// Top of the row-activation timing guard for a multi-bank SDRAM.
// Grants a request only when no bank or cross-bank limit would be broken.
// Assumes the requester keeps its request stable until granted.
module sdram_act_guard
    import sdram_guard_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 8,
    parameter int T_RCD_NS      = 18,
    parameter int T_RC_NS       = 60,
    parameter int T_RRD_NS      = 12,
    parameter int T_RP_NS       = 18,
    parameter int BA_W          = 2,
    parameter int ADDR_W        = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_cmd,
    input  logic [BA_W-1:0]   req_bank,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              grant,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);
    localparam int NUM_BANKS = 1 << BA_W;
    localparam int RCD_CYC   = ns_to_cyc(T_RCD_NS, CLK_PERIOD_NS);
    localparam int RC_CYC    = ns_to_cyc(T_RC_NS, CLK_PERIOD_NS);
    localparam int RRD_CYC   = ns_to_cyc(T_RRD_NS, CLK_PERIOD_NS);
    localparam int RP_CYC    = ns_to_cyc(T_RP_NS, CLK_PERIOD_NS);
    localparam int MAX_CYC   = (RC_CYC > RRD_CYC) ? RC_CYC : RRD_CYC;
    localparam int CNT_W     = cnt_width(MAX_CYC);

    req_cmd_e             cmd;
    logic [NUM_BANKS-1:0] bank_open;
    logic [NUM_BANKS-1:0] bank_rw_ok;
    logic [NUM_BANKS-1:0] bank_act_ok;
    logic [NUM_BANKS-1:0] act_go;
    logic [NUM_BANKS-1:0] pre_go;
    logic                 rrd_done;
    logic                 legal;
    logic                 any_act;

    assign cmd = req_cmd_e'(req_cmd);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Steer granted ACTIVE and PRECHARGE to this bank's record.
        always_comb begin
            act_go[b] = grant && (cmd == CMD_ACT) && (req_bank == BA_W'(b));
            pre_go[b] = grant && (cmd == CMD_PRE) && (req_bank == BA_W'(b));
        end

        sdram_bank_state #(
            .RCD_CYC(RCD_CYC), .RC_CYC(RC_CYC), .RP_CYC(RP_CYC), .W(CNT_W)
        ) u_state (
            .clk(clk), .rst_n(rst_n),
            .act_go(act_go[b]), .pre_go(pre_go[b]),
            .is_open(bank_open[b]), .rw_ready(bank_rw_ok[b]),
            .act_ready(bank_act_ok[b])
        );
    end

    assign any_act = |act_go;

    sdram_delay_cnt #(.CYC(RRD_CYC), .W(CNT_W)) u_rrd (
        .clk(clk), .rst_n(rst_n), .start(any_act), .expired(rrd_done)
    );

    // Decide whether the present request respects every limit.
    always_comb begin
        unique case (cmd)
            CMD_ACT: legal = bank_act_ok[req_bank] && rrd_done;
            CMD_RD,
            CMD_WR:  legal = bank_rw_ok[req_bank];
            CMD_PRE: legal = 1'b1;
        endcase
    end

    assign grant = rst_n && req_valid && legal;

    sdram_cmd_encode #(.BA_W(BA_W), .ADDR_W(ADDR_W)) u_enc (
        .clk(clk), .rst_n(rst_n), .fire(grant), .cmd(cmd),
        .bank(req_bank), .addr_in(req_addr),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr)
    );
endmodule

// File: rtl/sdram_act_guard_chk.sv
// Checker for the row-activation timing guard, bound to the top.
// It keeps its own cycle counts since each ACTIVE and PRECHARGE.
module sdram_act_guard_chk #(
    parameter int RCD_CYC = 3,
    parameter int RC_CYC  = 7,
    parameter int RRD_CYC = 2,
    parameter int RP_CYC  = 2,
    parameter int BA_W    = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            grant,
    input logic [1:0]      req_cmd,
    input logic [BA_W-1:0] req_bank,
    input logic            cs_n,
    input logic            ras_n,
    input logic            cas_n,
    input logic            we_n,
    input logic [BA_W-1:0] ba,
    input logic [(1<<BA_W)-1:0] bank_open
);
    localparam int NB = 1 << BA_W;
    localparam logic [15:0] SAT = 16'hFFFF;

    logic [15:0] since_any_act;
    logic [15:0] since_act [NB];
    logic [15:0] since_pre [NB];
    logic        is_act;
    logic        is_rw;
    logic        is_pre;

    assign is_act = grant && (req_cmd == 2'd0);
    assign is_rw  = grant && (req_cmd == 2'd1 || req_cmd == 2'd2);
    assign is_pre = grant && (req_cmd == 2'd3);

    // Count cycles since the latest ACTIVE to any bank.
    always_ff @(posedge clk) begin
        if (!rst_n) since_any_act <= SAT;
        else if (is_act) since_any_act <= 16'd1;
        else if (since_any_act != SAT) since_any_act <= since_any_act + 16'd1;
    end

    for (genvar b = 0; b < NB; b++) begin : g_chk
        // Count cycles since this bank's latest ACTIVE and PRECHARGE.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                since_act[b] <= SAT;
                since_pre[b] <= SAT;
            end else begin
                if (is_act && req_bank == BA_W'(b)) since_act[b] <= 16'd1;
                else if (since_act[b] != SAT) since_act[b] <= since_act[b] + 16'd1;
                if (is_pre && req_bank == BA_W'(b)) since_pre[b] <= 16'd1;
                else if (since_pre[b] != SAT) since_pre[b] <= since_pre[b] + 16'd1;
            end
        end

        // R5: column access waits RCD cycles after activation.
        a_r5_rcd_gap: assert property (@(posedge clk) disable iff (!rst_n)
            (is_rw && req_bank == BA_W'(b)) |-> (since_act[b] >= 16'(RCD_CYC)));
        // R7: same-bank activations spaced by RC.
        a_r7_rc_gap: assert property (@(posedge clk) disable iff (!rst_n)
            (is_act && req_bank == BA_W'(b)) |-> (since_act[b] >= 16'(RC_CYC)));
        // R9: activation waits RP cycles after precharge.
        a_r9_rp_gap: assert property (@(posedge clk) disable iff (!rst_n)
            (is_act && req_bank == BA_W'(b)) |-> (since_pre[b] >= 16'(RP_CYC)));
    end

    // R8: any two activations spaced by RRD.
    a_r8_rrd_gap: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |-> (since_any_act >= 16'(RRD_CYC)));
    // R4: column access only to an open bank.
    a_r4_rw_open: assert property (@(posedge clk) disable iff (!rst_n)
        is_rw |-> bank_open[req_bank]);
    // R6: activation only to a closed bank.
    a_r6_act_closed: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |-> !bank_open[req_bank]);
    // R10: a granted precharge leaves the bank closed.
    a_r10_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |=> !bank_open[$past(req_bank)]);
    // R3: no grant means NOP on the next bus cycle.
    a_r3_idle_nop: assert property (@(posedge clk) disable iff (!rst_n)
        !grant |=> (!cs_n && ras_n && cas_n && we_n));
    // R2: a grant puts its bank on the bus one cycle later.
    a_r2_bank_follows: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> (!cs_n && ba == $past(req_bank)));
endmodule

bind sdram_act_guard sdram_act_guard_chk #(
    .RCD_CYC(RCD_CYC), .RC_CYC(RC_CYC), .RRD_CYC(RRD_CYC),
    .RP_CYC(RP_CYC), .BA_W(BA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .grant(grant), .req_cmd(req_cmd),
    .req_bank(req_bank), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .bank_open(bank_open)
);

// File: tb/tb_sdram_act_guard.sv
// Directed bench for the row-activation timing guard.
module tb_sdram_act_guard;
    localparam int PER  = 10;
    localparam int E_RCD = (25 + PER - 1) / PER;  // 3
    localparam int E_RC  = (65 + PER - 1) / PER;  // 7
    localparam int E_RRD = (15 + PER - 1) / PER;  // 2
    localparam int E_RP  = (20 + PER - 1) / PER;  // 2

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_cmd = 2'd0;
    logic [1:0]  req_bank = 2'd0;
    logic [11:0] req_addr = 12'd0;
    logic        grant, cs_n, ras_n, cas_n, we_n;
    logic [1:0]  ba;
    logic [11:0] addr;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sdram_act_guard #(
        .CLK_PERIOD_NS(PER), .T_RCD_NS(25), .T_RC_NS(65),
        .T_RRD_NS(15), .T_RP_NS(20)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_bank(req_bank), .req_addr(req_addr), .grant(grant),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] bus_code(input logic [1:0] c);
        case (c)
            2'd0: return 4'b0011;
            2'd1: return 4'b0101;
            2'd2: return 4'b0100;
            default: return 4'b0010;
        endcase
    endfunction

    // Request a command, measure stall cycles, then check the bus after grant.
    task automatic issue(input logic [1:0] c, input logic [1:0] b,
                         input logic [11:0] a, input int exp_wait, input string req);
        int w;
        @(negedge clk);
        req_valid = 1'b1; req_cmd = c; req_bank = b; req_addr = a;
        #1;
        w = 0;
        while (!grant && w < 200) begin
            @(negedge clk); #1; w++;
        end
        chk(w == exp_wait, req, "stall cycles", w, exp_wait);
        @(posedge clk); #1;
        req_valid = 1'b0;
        chk({cs_n, ras_n, cas_n, we_n} == bus_code(c), "R2", "bus code",
            int'({cs_n, ras_n, cas_n, we_n}), int'(bus_code(c)));
        chk(ba == b && addr == a, "R2", "bus bank/addr",
            int'({ba, addr}), int'({b, a}));
    endtask

    // Hold a request that must not be granted; check grant low and bus NOP.
    task automatic stall(input logic [1:0] c, input logic [1:0] b,
                         input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == 0) begin
                req_valid = 1'b1; req_cmd = c; req_bank = b; req_addr = 12'h0AA;
            end
            #1;
            chk(grant == 1'b0, req, "grant while held off", int'(grant), 0);
            @(posedge clk); #1;
            chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R3", "bus NOP",
                int'({cs_n, ras_n, cas_n, we_n}), 7);
        end
        req_valid = 1'b0;
    endtask

    task automatic t_reset_and_first;
        @(negedge clk); #1;
        chk(grant == 1'b0, "R1", "grant in reset", int'(grant), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1", "bus after reset",
            int'({cs_n, ras_n, cas_n, we_n}), 7);
        issue(2'd0, 2'd0, 12'h123, 0, "R1");          // first ACTIVE at once
        issue(2'd1, 2'd0, 12'h045, E_RCD - 1, "R5");  // READ after RCD
        issue(2'd2, 2'd0, 12'h046, 0, "R5");          // WRITE, RCD already met
    endtask

    task automatic t_cross_bank;
        issue(2'd0, 2'd1, 12'h200, 0, "R8");
        issue(2'd0, 2'd2, 12'h300, E_RRD - 1, "R8");  // back-to-back ACTIVE
        issue(2'd2, 2'd2, 12'h010, E_RCD - 1, "R5");  // WRITE gated by RCD
    endtask

    task automatic t_open_bank;
        stall(2'd0, 2'd1, 5, "R6");                   // ACTIVE to open bank
        issue(2'd3, 2'd1, 12'h000, 0, "R10");
        issue(2'd0, 2'd1, 12'h201, E_RP - 1, "R9");   // only RP left to wait
    endtask

    task automatic t_same_bank;
        issue(2'd0, 2'd3, 12'h3F0, E_RRD - 1, "R8");
        issue(2'd3, 2'd3, 12'h000, 0, "R10");
        issue(2'd0, 2'd3, 12'h3F1, E_RC - 2, "R7");   // RC outlasts RP
    endtask

    task automatic t_closed_rw;
        issue(2'd3, 2'd0, 12'h000, 0, "R10");
        stall(2'd1, 2'd0, 4, "R4");
        issue(2'd3, 2'd0, 12'h000, 0, "R10");         // precharge of closed bank
        stall(2'd2, 2'd0, 3, "R10");                  // still closed
    endtask

    task automatic t_mid_reset;
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        stall(2'd1, 2'd2, 3, "R1");                   // bank 2 closed by reset
        issue(2'd0, 2'd2, 12'h301, 0, "R1");          // timers cleared
    endtask

    initial begin
        #(PER * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset_and_first();
        t_cross_bank();
        t_open_bank();
        t_same_bank();
        t_closed_rw();
        t_mid_reset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule